// File: doc/BRIEF.md
# Adaptive Interrupt Acceptance Holdoff

This block sits between the interrupt controller and the processor's interrupt-accept logic. Sometimes the processor starts to take an interrupt and then has to drop it, because an instruction already in the pipeline has turned interrupts off. The processor reports this with a one-cycle deferral pulse. The block then refuses new interrupt acceptances for a number of clock cycles. During that window the interrupted code can run forward instead of being flushed again and again by the same interrupt.

The window length adapts. The first deferral after a reset, or after an interrupt-enable instruction, uses the minimum length, set by parameter to 10 cycles. Each further deferral, with no enable instruction in between, doubles the length up to a ceiling of 640 cycles. When the processor executes an interrupt-enable instruction it sends a pulse, and that pulse brings the length back to the minimum. The outputs are a gated accept-allowed signal and the length that the next deferral would load.

A small state machine tracks the holdoff:

- It starts in IDLE, where the length is at its minimum and nothing is blocked.
- A deferral moves it from IDLE to HOLD. In HOLD the down-counter is running and acceptance is blocked. A deferral while in HOLD stays in HOLD and reloads the counter.
- When the counter expires, HOLD returns to IDLE if the length is back at its minimum. Otherwise it goes to STALL, meaning the window ended with the grown length still in place.
- From STALL, a deferral goes back to HOLD with a longer window, and an enable instruction returns to IDLE.

Top module: `irq_holdoff`

## Requirements
- R1: After synchronous active-high reset the hold length output is the minimum (10) and no holdoff is running, so acceptance follows the pending and enabled inputs at once.
- R2: The accept output is high exactly when interrupt-pending is high, interrupts-enabled is high and no holdoff is running. It depends combinationally on the two inputs.
- R3: A deferral pulse sampled at a clock edge starts a holdoff. The accept output is low for exactly N cycles after that edge, where N is the hold length shown before the edge, and rises on the edge N cycles later.
- R4: Each deferral without an enable pulse in the same cycle doubles the hold length output (10, 20, 40, 80, 160, 320, 640).
- R5: The hold length saturates at 640. A deferral at 640 loads a 640-cycle holdoff and leaves the length at 640.
- R6: A deferral that arrives while a holdoff is running restarts the counter with the current (already grown) length and grows the length again.
- R7: An enable pulse sets the hold length to the minimum on the next edge. A holdoff that is already running is not shortened.
- R8: When a deferral and an enable pulse come in the same cycle, the counter loads the length shown before the edge and the hold length returns to the minimum.
- R9: When a holdoff expires with the length above the minimum (STALL), the grown length is kept for any number of idle cycles until an enable pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| defer_i | input | 1 | One-cycle pulse: an interrupt that was begun had to be abandoned |
| ien_exec_i | input | 1 | One-cycle pulse: an interrupt-enable instruction executed |
| irq_pending_i | input | 1 | Raw interrupt-pending request from the controller |
| irq_enabled_i | input | 1 | Interrupts currently enabled in the processor |
| accept_ok_o | output | 1 | The processor may accept the pending interrupt now |
| hold_len_o | output | 10 | Holdoff length, in cycles, that the next deferral would load |

## Verification
The hardest condition to reach from the ports is the saturated end of the doubling chain. Getting there needs six deferrals in a row, each arriving after the previous window has ended, with no enable pulse in between. The bench fires each deferral only after it has timed the previous window to the cycle, so every step of the chain is checked. A second hard case is the defer-and-enable collision, which needs both pulses on the same edge while the length is already grown; the bench sets up the grown length first and then drives both pulses together.

// File: rtl/irqh_pkg.sv
`timescale 1ns/1ps
package irqh_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HOLD  = 2'd1,
        S_STALL = 2'd2
    } hold_state_e;
endpackage

// File: rtl/irqh_len.sv
`timescale 1ns/1ps
// Holdoff length register: doubles on a deferral, returns to minimum on enable.
module irqh_len #(
    parameter int MIN_LEN = 10,
    parameter int MAX_LEN = 640,
    parameter int CW      = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          grow,
    input  logic          shrink,
    output logic [CW-1:0] len_o,
    output logic          at_min_o
);
    localparam logic [CW-1:0] MINV = CW'(MIN_LEN);
    localparam logic [CW-1:0] MAXV = CW'(MAX_LEN);

    logic [CW-1:0] len_q;
    logic [CW:0]   dbl;
    logic [CW-1:0] grown;

    always_comb begin
        dbl   = {len_q, 1'b0};
        grown = (dbl >= {1'b0, MAXV}) ? MAXV : dbl[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)         len_q <= MINV;
        else if (shrink) len_q <= MINV;
        else if (grow)   len_q <= grown;
    end

    assign len_o    = len_q;
    assign at_min_o = (len_q == MINV);
endmodule

// File: rtl/irqh_timer.sv
`timescale 1ns/1ps
// Holdoff down-counter with load and expiry flag.
module irqh_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign cnt_o    = cnt_q;
    assign expire_o = (cnt_q == CW'(1)) && !load;
endmodule

// File: rtl/irqh_fsm.sv
`timescale 1ns/1ps
// Holdoff phase tracker: IDLE, HOLD, STALL.
module irqh_fsm
    import irqh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic defer,
    input  logic ien,
    input  logic expire,
    input  logic len_at_min,
    output logic hold_o
);
    hold_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= S_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (defer) st_d = S_HOLD;
            end
            S_HOLD: begin
                if (defer)       st_d = S_HOLD;
                else if (expire) st_d = (ien || len_at_min) ? S_IDLE : S_STALL;
            end
            S_STALL: begin
                if (defer)    st_d = S_HOLD;
                else if (ien) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        hold_o = (st_q == S_HOLD);
    end
endmodule

// File: rtl/irq_holdoff.sv
`timescale 1ns/1ps
// Adaptive interrupt acceptance holdoff (top).
module irq_holdoff #(
    parameter int MIN_LEN = 10,
    parameter int MAX_LEN = 640,
    localparam int CW     = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          defer_i,
    input  logic          ien_exec_i,
    input  logic          irq_pending_i,
    input  logic          irq_enabled_i,
    output logic          accept_ok_o,
    output logic [CW-1:0] hold_len_o
);
    logic [CW-1:0] len;
    logic          len_at_min;
    logic [CW-1:0] cnt;
    logic          expire;
    logic          hold;

    irqh_len #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CW(CW)) u_len (
        .clk      (clk),
        .rst      (rst),
        .grow     (defer_i),
        .shrink   (ien_exec_i),
        .len_o    (len),
        .at_min_o (len_at_min)
    );

    irqh_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (defer_i),
        .load_val (len),
        .cnt_o    (cnt),
        .expire_o (expire)
    );

    irqh_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .defer      (defer_i),
        .ien        (ien_exec_i),
        .expire     (expire),
        .len_at_min (len_at_min),
        .hold_o     (hold)
    );

    assign accept_ok_o = irq_pending_i && irq_enabled_i && !hold;
    assign hold_len_o  = len;
endmodule

// File: rtl/irq_holdoff_chk.sv
`timescale 1ns/1ps
module irq_holdoff_chk #(
    parameter int MIN_LEN = 10,
    parameter int MAX_LEN = 640,
    parameter int CW      = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          defer_i,
    input logic          ien_exec_i,
    input logic          irq_pending_i,
    input logic          irq_enabled_i,
    input logic          accept_ok_o,
    input logic [CW-1:0] hold_len_o,
    input logic [CW-1:0] cnt
);
    logic [CW:0]   dbl_c;
    logic [CW-1:0] grown_c;
    always_comb begin
        dbl_c   = {hold_len_o, 1'b0};
        grown_c = (dbl_c >= (CW+1)'(MAX_LEN)) ? CW'(MAX_LEN) : dbl_c[CW-1:0];
    end

    // R2
    accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
        accept_ok_o |-> (irq_pending_i && irq_enabled_i));

    // R3
    defer_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        defer_i |=> !accept_ok_o);

    // R3
    count_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0) |-> !accept_ok_o);

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!defer_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R6
    reload_len_chk: assert property (@(posedge clk) disable iff (rst)
        defer_i |=> (cnt == $past(hold_len_o)));

    // R4
    double_len_chk: assert property (@(posedge clk) disable iff (rst)
        (defer_i && !ien_exec_i) |=> (hold_len_o == $past(grown_c)));

    // R7
    enable_min_chk: assert property (@(posedge clk) disable iff (rst)
        ien_exec_i |=> (hold_len_o == CW'(MIN_LEN)));

    // R5
    always @(posedge clk) begin
        if (!rst) begin
            len_range_chk: assert (hold_len_o >= CW'(MIN_LEN) && hold_len_o <= CW'(MAX_LEN));
        end
    end
endmodule

bind irq_holdoff irq_holdoff_chk #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .defer_i       (defer_i),
    .ien_exec_i    (ien_exec_i),
    .irq_pending_i (irq_pending_i),
    .irq_enabled_i (irq_enabled_i),
    .accept_ok_o   (accept_ok_o),
    .hold_len_o    (hold_len_o),
    .cnt           (cnt)
);

// File: tb/sim_irq_holdoff.sv
`timescale 1ns/1ps
module sim_irq_holdoff;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       defer_i = 1'b0;
    logic       ien_exec_i = 1'b0;
    logic       irq_pending_i = 1'b0;
    logic       irq_enabled_i = 1'b0;
    logic       accept_ok_o;
    logic [9:0] hold_len_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_holdoff u0 (
        .clk           (clk),
        .rst           (rst),
        .defer_i       (defer_i),
        .ien_exec_i    (ien_exec_i),
        .irq_pending_i (irq_pending_i),
        .irq_enabled_i (irq_enabled_i),
        .accept_ok_o   (accept_ok_o),
        .hold_len_o    (hold_len_o)
    );

    // R2 vectors: {defer first, pending, enabled, expected accept}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0010, 4'b0100, 4'b0111,
        4'b1000, 4'b1010, 4'b1100, 4'b1110
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!accept_ok_o && n < 2000) begin
            tick();
            n++;
        end
    endtask

    task automatic pulse_defer();
        defer_i = 1'b1; tick(); defer_i = 1'b0;
    endtask

    task automatic pulse_ien();
        ien_exec_i = 1'b1; tick(); ien_exec_i = 1'b0;
    endtask

    initial begin
        #600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int exp_hold;
        int exp_len;
        irq_pending_i = 1'b1;
        irq_enabled_i = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        #1;
        chk("R1 accept after reset", accept_ok_o, 1);
        chk("R1 length after reset", hold_len_o, 10);

        // R2 table walk
        foreach (VEC[i]) begin
            irq_pending_i = 1'b0;
            irq_enabled_i = 1'b0;
            pulse_ien();
            repeat (12) tick();
            irq_pending_i = VEC[i][2];
            irq_enabled_i = VEC[i][1];
            if (VEC[i][3]) pulse_defer();
            #1;
            chk($sformatf("R2 vector %0d", i), accept_ok_o, VEC[i][0]);
        end
        pulse_ien();
        repeat (12) tick();
        irq_pending_i = 1'b1;
        irq_enabled_i = 1'b1;
        #1;
        chk("R1 length at minimum before R3", hold_len_o, 10);

        // R3: first window is the minimum
        pulse_defer();
        chk("R3 blocked right after deferral", accept_ok_o, 0);
        measure(n);
        chk("R3 minimum holdoff cycles", n, 10);
        chk("R4 length after first deferral", hold_len_o, 20);

        // R9: grown length persists while idle
        repeat (50) tick();
        chk("R9 length kept in stall", hold_len_o, 20);
        chk("R9 accept open in stall", accept_ok_o, 1);

        // R4 / R5 doubling chain
        exp_hold = 20;
        for (int i = 0; i < 6; i++) begin
            pulse_defer();
            measure(n);
            exp_len = (exp_hold * 2 > 640) ? 640 : exp_hold * 2;
            chk($sformatf("%s holdoff cycles step %0d", (i >= 4) ? "R5" : "R4", i), n, exp_hold);
            chk($sformatf("%s length step %0d", (i >= 4) ? "R5" : "R4", i), hold_len_o, exp_len);
            exp_hold = exp_len;
        end

        // R7: enable resets length, running window unchanged
        pulse_ien();
        chk("R7 length after enable", hold_len_o, 10);
        pulse_defer();
        pulse_ien();
        chk("R7 length reset during hold", hold_len_o, 10);
        measure(n);
        chk("R7 running holdoff not shortened", n, 9);

        // R6: deferral during a running holdoff
        pulse_defer();
        tick();
        tick();
        pulse_defer();
        chk("R6 length after second deferral", hold_len_o, 40);
        measure(n);
        chk("R6 restarted holdoff cycles", n, 20);

        // R8: deferral and enable together
        defer_i = 1'b1;
        ien_exec_i = 1'b1;
        tick();
        defer_i = 1'b0;
        ien_exec_i = 1'b0;
        chk("R8 length after collision", hold_len_o, 10);
        measure(n);
        chk("R8 holdoff uses prior length", n, 40);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule